// File: doc/BRIEF.md
# Dual-Region Segment Access Checker

This block checks each memory reference aimed at a segment that is split into two regions by one dividing point. Plain scalar values live at offsets at or above that point and grow upward; capability descriptors live at offsets below it and grow downward. A segment may fill both regions, or only one, in which case the other has length zero.

A requester offers a segment description with a valid/ready handshake. The description is the boundary address, the length of the scalar region and the length of the capability region. With it come a signed offset, the kind of operation (scalar or capability) and a read/write flag. One cycle after the request is accepted, the block presents either a physical address with a single read or write strobe, or a fault code with no strobe. An operation may only touch the region of its own kind. The response is held until the consumer takes it.

Top module: `seg_access_chk`

## Requirements
- R1: A scalar operation (`req_kind` = 0) with offset k, where 0 <= k < data length, returns fault code 0 and address (base + k) modulo 2^AW.
- R2: A capability operation (`req_kind` = 1) with offset k, where -cap length <= k < 0, returns fault code 0 and address (base + k) modulo 2^AW.
- R3: A scalar operation with a negative offset returns fault code 1 (wrong region).
- R4: A capability operation with a non-negative offset returns fault code 1 (wrong region).
- R5: An operation whose offset lies in its own region but past that region's length returns fault code 2 (out of bounds). This includes every offset of the right sign when that region has length zero.
- R6: Whenever the fault code is not 0, the reported address is zero.
- R7: `req_ready` equals (not `rsp_valid`) or `rsp_ready`. A request accepted on one edge appears on the response outputs after that edge. The response stays unchanged while `rsp_valid` is high and `rsp_ready` is low.
- R8: `rsp_rd_stb` is high exactly when a response is valid, its fault code is 0 and it is a read. `rsp_wr_stb` is high in the same case for a write. Neither is high while a fault is reported.
- R9: While reset is asserted and just after it, `rsp_valid`, both strobes and the fault code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_base | input | AW | Address of the dividing point between the regions |
| req_data_len | input | LW | Length of the scalar region |
| req_cap_len | input | LW | Length of the capability region |
| req_offset | input | OW | Signed offset from the dividing point |
| req_kind | input | 1 | 0 = scalar operation, 1 = capability operation |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | AW | Physical address (zero on fault) |
| rsp_fault | output | 2 | 0 ok, 1 wrong region, 2 out of bounds |
| rsp_rd_stb | output | 1 | Read strobe |
| rsp_wr_stb | output | 1 | Write strobe |

## Verification
The properties assume that the request fields are known whenever `req_valid` is high. They also assume AW is at least OW, so that sign extension of the offset is exact. The stimulus picks offsets clustered at both edges of each region and on either side of the dividing point. It includes zero-length regions and bases near the top of the address space, so the modular address wraps. Both `req_valid` and `rsp_ready` are toggled at random, which exercises stalls, back-to-back transfers and held responses.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_REGION = 2'd1,
        FLT_BOUNDS = 2'd2
    } fault_e;

    typedef enum logic {
        OP_SCALAR = 1'b0,
        OP_CAPAB  = 1'b1
    } op_kind_e;

endpackage

// File: rtl/seg_bound_cmp.sv
// Decides whether an offset lies on the side of the dividing point that
// belongs to one region, and whether it is within that region's length.
module seg_bound_cmp #(
    parameter int OW  = 17,
    parameter int LW  = 16,
    parameter bit NEG = 1'b0
) (
    input  logic [OW-1:0] off,
    input  logic [LW-1:0] len,
    output logic          on_side,
    output logic          in_len
);
    localparam int CW = ((OW > LW) ? OW : LW) + 2;

    logic signed [CW-1:0] off_w;
    logic signed [CW-1:0] len_w;

    assign off_w = CW'(signed'(off));
    assign len_w = signed'(CW'(len));

    generate
        if (NEG) begin : g_down
            assign on_side = off[OW-1];
            assign in_len  = on_side && ((-off_w) <= len_w);
        end else begin : g_up
            assign on_side = ~off[OW-1];
            assign in_len  = on_side && (off_w < len_w);
        end
    endgenerate
endmodule

// File: rtl/seg_addr_gen.sv
// Adds a sign-extended offset to the boundary address, wrapping at 2^AW.
module seg_addr_gen #(
    parameter int AW = 32,
    parameter int OW = 17
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] off,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] off_x;

    generate
        if (AW > OW) begin : g_ext
            assign off_x = {{(AW-OW){off[OW-1]}}, off};
        end else begin : g_cut
            assign off_x = off[AW-1:0];
        end
    endgenerate

    assign addr = base + off_x;
endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
    import seg_chk_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int OW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_base,
    input  logic [LW-1:0] req_data_len,
    input  logic [LW-1:0] req_cap_len,
    input  logic [OW-1:0] req_offset,
    input  logic          req_kind,
    input  logic          req_write,
    input  logic          rsp_ready,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr,
    output logic [1:0]    rsp_fault,
    output logic          rsp_rd_stb,
    output logic          rsp_wr_stb
);
    typedef struct packed {
        logic          valid;
        fault_e        fault;
        logic [AW-1:0] addr;
        logic          write;
    } rsp_t;

    rsp_t r_d, r_q;

    logic          up_side, up_ok;
    logic          dn_side, dn_ok;
    logic [AW-1:0] phys;
    logic          accept;
    fault_e        flt_c;

    seg_bound_cmp #(.OW(OW), .LW(LW), .NEG(1'b0)) u_up (
        .off     (req_offset),
        .len     (req_data_len),
        .on_side (up_side),
        .in_len  (up_ok)
    );

    seg_bound_cmp #(.OW(OW), .LW(LW), .NEG(1'b1)) u_dn (
        .off     (req_offset),
        .len     (req_cap_len),
        .on_side (dn_side),
        .in_len  (dn_ok)
    );

    seg_addr_gen #(.AW(AW), .OW(OW)) u_addr (
        .base (req_base),
        .off  (req_offset),
        .addr (phys)
    );

    assign req_ready = ~r_q.valid | rsp_ready;
    assign accept    = req_valid & req_ready;

    always_comb begin
        // region decided by sign first, then the length of that region
        if (op_kind_e'(req_kind) == OP_SCALAR) begin
            flt_c = !up_side ? FLT_REGION : (!up_ok ? FLT_BOUNDS : FLT_NONE);
        end else begin
            flt_c = !dn_side ? FLT_REGION : (!dn_ok ? FLT_BOUNDS : FLT_NONE);
        end

        r_d = r_q;
        if (accept) begin
            r_d.valid = 1'b1;
            r_d.fault = flt_c;
            r_d.addr  = (flt_c == FLT_NONE) ? phys : '0;
            r_d.write = req_write;
        end else if (rsp_ready) begin
            r_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{valid: 1'b0, fault: FLT_NONE, addr: '0, write: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid  = r_q.valid;
    assign rsp_addr   = r_q.addr;
    assign rsp_fault  = r_q.fault;
    assign rsp_rd_stb = r_q.valid & (r_q.fault == FLT_NONE) & ~r_q.write;
    assign rsp_wr_stb = r_q.valid & (r_q.fault == FLT_NONE) &  r_q.write;
endmodule

// File: rtl/seg_access_chk_sva.sv
module seg_access_chk_sva #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int OW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [OW-1:0] req_offset,
    input logic          req_kind,
    input logic          rsp_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] rsp_addr,
    input logic [1:0]    rsp_fault,
    input logic          rsp_rd_stb,
    input logic          rsp_wr_stb
);
    logic acc;
    assign acc = req_valid && req_ready;

    AST_SCALAR_NEG_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !req_kind && req_offset[OW-1] |=> rsp_valid && rsp_fault == 2'd1); // R3
    AST_CAPAB_POS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_kind && !req_offset[OW-1] |=> rsp_valid && rsp_fault == 2'd1); // R4
    AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 2'd0 |-> rsp_addr == '0); // R6
    AST_ACCEPT_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid); // R7
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)); // R7
    AST_NO_STB_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != 2'd0 |-> !rsp_rd_stb && !rsp_wr_stb); // R8
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_rd_stb, rsp_wr_stb})); // R8
    AST_STB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rd_stb || rsp_wr_stb) |-> rsp_valid); // R8
    AST_NO_CODE_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != 2'd3); // R5
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid && !rsp_rd_stb && !rsp_wr_stb); // R9
endmodule

bind seg_access_chk seg_access_chk_sva #(.AW(AW), .LW(LW), .OW(OW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_offset (req_offset),
    .req_kind   (req_kind),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_addr   (rsp_addr),
    .rsp_fault  (rsp_fault),
    .rsp_rd_stb (rsp_rd_stb),
    .rsp_wr_stb (rsp_wr_stb)
);

// File: tb/seg_access_chk_tb.sv
`timescale 1ns/1ps
module seg_access_chk_tb;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int OW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_base = '0;
    logic [LW-1:0] req_data_len = '0;
    logic [LW-1:0] req_cap_len = '0;
    logic [OW-1:0] req_offset = '0;
    logic          req_kind = 1'b0;
    logic          req_write = 1'b0;
    logic          rsp_ready = 1'b0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_addr;
    logic [1:0]    rsp_fault;
    logic          rsp_rd_stb;
    logic          rsp_wr_stb;

    always #2 clk = ~clk;

    seg_access_chk #(.AW(AW), .LW(LW), .OW(OW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_data_len(req_data_len), .req_cap_len(req_cap_len),
        .req_offset(req_offset), .req_kind(req_kind), .req_write(req_write),
        .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .rsp_rd_stb(rsp_rd_stb), .rsp_wr_stb(rsp_wr_stb)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // reference model state
    bit      m_valid = 0;
    int      m_fault = 0;
    longint  m_addr = 0;
    bit      m_write = 0;
    string   m_tag = "R9";

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_valid = 0; m_fault = 0; m_addr = 0; m_write = 0; m_tag = "R9";
        end else if (req_valid && (!m_valid || rsp_ready)) begin
            longint k, dl, cl;
            k  = longint'(signed'(req_offset));
            dl = longint'(req_data_len);
            cl = longint'(req_cap_len);
            m_valid = 1;
            m_write = req_write;
            if (!req_kind) begin
                if (k < 0)        begin m_fault = 1; m_tag = "R3"; end
                else if (k >= dl) begin m_fault = 2; m_tag = "R5"; end
                else              begin m_fault = 0; m_tag = "R1"; end
            end else begin
                if (k >= 0)       begin m_fault = 1; m_tag = "R4"; end
                else if (-k > cl) begin m_fault = 2; m_tag = "R5"; end
                else              begin m_fault = 0; m_tag = "R2"; end
            end
            m_addr = (m_fault == 0) ? ((longint'(req_base) + k) & 64'hFFFF_FFFF) : 0;
        end else if (rsp_ready) begin
            m_valid = 0;
        end
        if (cyc > 200000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
            finish_run();
        end
    end

    task automatic compare_all();
        check("R7 ready", req_ready, !m_valid || rsp_ready);
        check("R7 valid", rsp_valid, m_valid);
        if (m_valid) begin
            check({m_tag, " fault"}, rsp_fault, m_fault);
            check(m_fault == 0 ? {m_tag, " addr"} : "R6 addr", rsp_addr, m_addr);
        end
        check("R8 rd_stb", rsp_rd_stb, m_valid && m_fault == 0 && !m_write);
        check("R8 wr_stb", rsp_wr_stb, m_valid && m_fault == 0 && m_write);
    endtask

    function automatic longint pick_off(bit kind, longint dl, longint cl);
        int s = $urandom_range(0, 9);
        longint lim = kind ? -cl : dl;
        case (s)
            0: return 0;
            1: return -1;
            2: return lim;
            3: return kind ? lim - 1 : lim - 1;
            4: return kind ? lim + 1 : lim + 1;
            5: return -longint'($urandom_range(0, 65536));
            6: return longint'($urandom_range(0, 65535));
            7: return kind ? -longint'($urandom_range(1, 8)) : longint'($urandom_range(0, 8));
            default: return kind ? -longint'($urandom_range(1, 70000) % 65537)
                                 : longint'($urandom_range(0, 70000) % 65536);
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 valid", rsp_valid, 0);
        check("R9 rd_stb", rsp_rd_stb, 0);
        check("R9 wr_stb", rsp_wr_stb, 0);
        check("R9 fault", rsp_fault, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            compare_all();
            begin
                longint dl, cl, k;
                int ls = $urandom_range(0, 4);
                dl = (ls == 0) ? 0 : (ls == 1) ? 1 : longint'($urandom_range(0, 65535));
                ls = $urandom_range(0, 4);
                cl = (ls == 0) ? 0 : (ls == 1) ? 1 : longint'($urandom_range(0, 65535));
                req_kind     = $urandom_range(0, 1);
                k            = pick_off(req_kind, dl, cl);
                if (k > 65535)  k = 65535;
                if (k < -65536) k = -65536;
                req_data_len = LW'(dl);
                req_cap_len  = LW'(cl);
                req_offset   = OW'(k);
                req_base     = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(0, 40))
                             : ($urandom_range(0, 2) == 0) ? (32'hFFFF_FFF0 + AW'($urandom_range(0, 15)))
                             : AW'($urandom);
                req_write    = $urandom_range(0, 1);
                req_valid    = ($urandom_range(0, 3) != 0);
                rsp_ready    = ($urandom_range(0, 3) != 0);
            end
        end
        @(negedge clk);
        compare_all();
        finish_run();
    end
endmodule